// File: doc/BRIEF.md
# Line Dimmer Type Classifier

This block decides how the AC line feeding a lamp driver is phase-cut. It receives a stream of digitised rectified-line samples and a strobe that closes each half line cycle. From these it reports one of three operating modes: no dimmer, leading-edge dimmer or trailing-edge dimmer. The boost and output controllers read a registered mode code, together with a flag that is high while the block is still learning.

Edges are found by comparing each valid sample with the previous valid sample of the same half cycle, using a low and a high threshold. After reset the block is in a learn phase. This phase lasts four half cycles and ends with a vote. When the vote finds a dimmer, the block moves to a validate phase. In that phase every sixteenth half cycle is classified again and compared with the running mode. The comparison results feed a saturating mismatch counter, which acts as a low-pass filter. When enough confirmed mismatches build up, the block goes back to learning. A single noisy half cycle cannot change the mode.

Top module: `dimcls_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `learning_o` is 1 and `mode_o` is 0 (code 0 = no dimmer, 1 = leading-edge, 2 = trailing-edge, 3 never used).
- R2: A leading-edge event occurs when a valid sample is above HI_TH (default 96) and the previous valid sample of the same half cycle was below LO_TH (default 32). Invalid cycles between the two samples do not break the pair. The first valid sample after a strobe has no predecessor and cannot raise an event.
- R3: A trailing-edge event occurs when a valid sample is below LO_TH and the previous valid sample of the same half cycle was above HI_TH.
- R4: A half cycle is classed as leading-edge if it held any leading-edge event, otherwise as trailing-edge if it held a trailing-edge event, otherwise as no dimmer. A valid sample in the same cycle as `half_stb` belongs to the half cycle that the strobe closes.
- R5: At the fourth strobe of a learn phase, the block picks a verdict. It is leading-edge if at least two of the four halves were classed leading-edge, otherwise trailing-edge if at least two were trailing-edge, otherwise no dimmer.
- R6: `mode_o` changes only at the strobe that ends a learn phase, and it is updated in the clock edge that samples that strobe.
- R7: A leading-edge or trailing-edge verdict drops `learning_o` to 0 (validate). A no-dimmer verdict keeps `learning_o` at 1 and starts a fresh four-half learn phase.
- R8: In validate, only the class of every sixteenth half cycle counted from entry (the 16th, 32nd, ... strobe) is compared with `mode_o`. All other halves have no effect.
- R9: Each compared half changes a mismatch count that starts at 0 on entry and is bounded to 0..15. A mismatch adds one and a match subtracts one, never going below 0. When the count reaches 12, `learning_o` returns to 1, `mode_o` keeps its value and the count is cleared.
- R10: While `learning_o` is 0, `mode_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Line sample valid |
| smp | input | SMP_W (8) | Rectified line sample, unsigned |
| half_stb | input | 1 | Closes the current half line cycle |
| mode_o | output | 2 | Operating mode code (0 none, 1 leading, 2 trailing) |
| learning_o | output | 1 | High during the learn phase |

## Verification
Edge detection and the half-cycle close can fall in the same cycle. This happens when a valid sample arrives together with `half_stb`. The bench provokes it with a half cycle whose steep drop to zero lands on the strobe sample. It judges the outcome by the learn verdict: the result is trailing-edge only if that last-sample drop was counted for the closing half. The validate check and the mismatch trip also share a strobe cycle with the class of that half. A behavioural model, compared on every clock, confirms that the return to learning happens in exactly that cycle and that the mode is held.

// File: rtl/dimcls_pkg.sv
package dimcls_pkg;

    typedef enum logic [1:0] {
        MODE_NONE  = 2'd0,
        MODE_LEAD  = 2'd1,
        MODE_TRAIL = 2'd2
    } dim_mode_e;

    typedef enum logic {
        PH_LEARN    = 1'b0,
        PH_VALIDATE = 1'b1
    } phase_e;

    typedef struct packed {
        logic lead;
        logic trail;
    } edge_flags_t;

    // Class of one half cycle: leading cut wins over trailing cut
    function automatic dim_mode_e half_class(edge_flags_t f);
        if (f.lead)
            return MODE_LEAD;
        else if (f.trail)
            return MODE_TRAIL;
        else
            return MODE_NONE;
    endfunction

    // Vote over a learn window
    function automatic dim_mode_e learn_verdict(int unsigned lead_n,
                                                int unsigned trail_n,
                                                int unsigned need);
        if (lead_n >= need)
            return MODE_LEAD;
        else if (trail_n >= need)
            return MODE_TRAIL;
        else
            return MODE_NONE;
    endfunction

endpackage

// File: rtl/dimcls_edge.sv
module dimcls_edge
    import dimcls_pkg::*;
#(
    parameter int SMP_W = 8,
    parameter int LO_TH = 32,
    parameter int HI_TH = 96
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_vld,
    input  logic [SMP_W-1:0] smp,
    input  logic             half_stb,
    output dim_mode_e        half_cls
);
    localparam logic [SMP_W-1:0] LO_V = SMP_W'(LO_TH);
    localparam logic [SMP_W-1:0] HI_V = SMP_W'(HI_TH);

    logic [SMP_W-1:0] prev_q;
    logic             have_prev_q;
    edge_flags_t      seen_q;
    edge_flags_t      now_f;
    edge_flags_t      acc_f;

    always_comb begin
        now_f.lead  = smp_vld && have_prev_q && (prev_q < LO_V) && (smp > HI_V);
        now_f.trail = smp_vld && have_prev_q && (prev_q > HI_V) && (smp < LO_V);
        acc_f       = seen_q | now_f;
        half_cls    = half_class(acc_f);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q      <= '0;
            have_prev_q <= 1'b0;
            seen_q      <= '0;
        end else if (half_stb) begin
            // a new half cycle starts without a predecessor sample
            have_prev_q <= 1'b0;
            seen_q      <= '0;
        end else begin
            seen_q <= acc_f;
            if (smp_vld) begin
                prev_q      <= smp;
                have_prev_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dimcls_tally.sv
module dimcls_tally
    import dimcls_pkg::*;
#(
    parameter int HALVES = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      stb,
    input  dim_mode_e cls,
    output logic      done,
    output dim_mode_e verdict
);
    localparam int CW   = $clog2(HALVES + 1);
    localparam int NEED = HALVES / 2;

    logic [CW-1:0] half_q;
    logic [CW-1:0] lead_q;
    logic [CW-1:0] trail_q;
    logic [CW-1:0] lead_n;
    logic [CW-1:0] trail_n;

    always_comb begin
        lead_n  = lead_q  + CW'(cls == MODE_LEAD);
        trail_n = trail_q + CW'(cls == MODE_TRAIL);
        done    = stb && (half_q == CW'(HALVES - 1));
        verdict = learn_verdict(int'(lead_n), int'(trail_n), NEED);
    end

    always_ff @(posedge clk) begin
        if (rst || clr || done) begin
            half_q  <= '0;
            lead_q  <= '0;
            trail_q <= '0;
        end else if (stb) begin
            half_q  <= half_q + 1'b1;
            lead_q  <= lead_n;
            trail_q <= trail_n;
        end
    end

endmodule

// File: rtl/dimcls_filt.sv
module dimcls_filt #(
    parameter int MAXV = 15,
    parameter int TRIP = 12,
    localparam int CW  = $clog2(MAXV + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          step,
    input  logic          miss,
    output logic [CW-1:0] cnt,
    output logic          trip
);
    assign trip = step && miss && (cnt == CW'(TRIP - 1));

    always_ff @(posedge clk) begin
        if (rst || clr || trip) begin
            cnt <= '0;
        end else if (step) begin
            if (miss)
                cnt <= (cnt == CW'(MAXV)) ? cnt : cnt + 1'b1;
            else
                cnt <= (cnt == '0) ? cnt : cnt - 1'b1;
        end
    end

endmodule

// File: rtl/dimcls_top.sv
module dimcls_top
    import dimcls_pkg::*;
#(
    parameter int SMP_W          = 8,
    parameter int LO_TH          = 32,
    parameter int HI_TH          = 96,
    parameter int LEARN_HALVES   = 4,
    parameter int RECHECK_HALVES = 16,
    parameter int FILT_MAX       = 15,
    parameter int FILT_TRIP      = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_vld,
    input  logic [SMP_W-1:0] smp,
    input  logic             half_stb,
    output logic [1:0]       mode_o,
    output logic             learning_o
);
    localparam int PW  = (RECHECK_HALVES > 1) ? $clog2(RECHECK_HALVES) : 1;
    localparam int FCW = $clog2(FILT_MAX + 1);

    phase_e         phase_q;
    dim_mode_e      mode_q;
    logic [PW-1:0]  per_q;
    dim_mode_e      half_cls;
    dim_mode_e      verdict;
    logic           learn_done;
    logic           check_now;
    logic           trip;
    logic [FCW-1:0] filt_cnt;

    dimcls_edge #(
        .SMP_W (SMP_W),
        .LO_TH (LO_TH),
        .HI_TH (HI_TH)
    ) u_edge (
        .clk      (clk),
        .rst      (rst),
        .smp_vld  (smp_vld),
        .smp      (smp),
        .half_stb (half_stb),
        .half_cls (half_cls)
    );

    dimcls_tally #(
        .HALVES (LEARN_HALVES)
    ) u_tally (
        .clk     (clk),
        .rst     (rst),
        .clr     (phase_q == PH_VALIDATE),
        .stb     (half_stb && (phase_q == PH_LEARN)),
        .cls     (half_cls),
        .done    (learn_done),
        .verdict (verdict)
    );

    assign check_now = half_stb && (phase_q == PH_VALIDATE)
                       && (per_q == PW'(RECHECK_HALVES - 1));

    dimcls_filt #(
        .MAXV (FILT_MAX),
        .TRIP (FILT_TRIP)
    ) u_filt (
        .clk  (clk),
        .rst  (rst),
        .clr  (phase_q == PH_LEARN),
        .step (check_now),
        .miss (half_cls != mode_q),
        .cnt  (filt_cnt),
        .trip (trip)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_LEARN;
            mode_q  <= MODE_NONE;
            per_q   <= '0;
        end else begin
            case (phase_q)
                PH_LEARN: begin
                    per_q <= '0;
                    if (learn_done) begin
                        mode_q <= verdict;
                        if (verdict != MODE_NONE)
                            phase_q <= PH_VALIDATE;
                    end
                end
                PH_VALIDATE: begin
                    if (half_stb)
                        per_q <= check_now ? '0 : per_q + 1'b1;
                    if (trip)
                        phase_q <= PH_LEARN;
                end
                default: phase_q <= PH_LEARN;
            endcase
        end
    end

    assign mode_o     = mode_q;
    assign learning_o = (phase_q == PH_LEARN);

endmodule

// File: rtl/dimcls_chk.sv
module dimcls_chk #(
    parameter int FCW       = 4,
    parameter int FILT_TRIP = 12
) (
    input logic           clk,
    input logic           rst,
    input logic           half_stb,
    input logic [1:0]     mode_o,
    input logic           learning_o,
    input logic [FCW-1:0] filt_cnt
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (learning_o && mode_o == 2'd0));

    a_r5_legal_code: assert property (@(posedge clk) disable iff (rst)
        mode_o != 2'd3);

    a_r6_mode_only_on_strobe: assert property (@(posedge clk) disable iff (rst)
        !half_stb |=> $stable(mode_o));

    a_r7_validate_has_dimmer: assert property (@(posedge clk) disable iff (rst)
        !learning_o |-> (mode_o != 2'd0));

    a_r7_leave_learn_on_strobe: assert property (@(posedge clk) disable iff (rst)
        $fell(learning_o) |-> $past(half_stb));

    a_r9_filter_below_trip: assert property (@(posedge clk) disable iff (rst)
        filt_cnt < FCW'(FILT_TRIP));

    a_r10_validate_holds_mode: assert property (@(posedge clk) disable iff (rst)
        !learning_o |=> $stable(mode_o));

endmodule

bind dimcls_top dimcls_chk #(
    .FCW       (FCW),
    .FILT_TRIP (FILT_TRIP)
) u_dimcls_chk (
    .clk        (clk),
    .rst        (rst),
    .half_stb   (half_stb),
    .mode_o     (mode_o),
    .learning_o (learning_o),
    .filt_cnt   (filt_cnt)
);

// File: tb/test_dimcls_top.sv
`timescale 1ns/1ps
module test_dimcls_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_vld = 1'b0;
    logic [7:0] smp = 8'd0;
    logic       half_stb = 1'b0;
    logic [1:0] mode_o;
    logic       learning_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dimcls_top i_dimcls_top (
        .clk        (clk),
        .rst        (rst),
        .smp_vld    (smp_vld),
        .smp        (smp),
        .half_stb   (half_stb),
        .mode_o     (mode_o),
        .learning_o (learning_o)
    );

    // ---------------- behavioural reference model ----------------
    int m_mode, m_learn, m_prev, m_hp, m_ls, m_ts;
    int m_hc, m_lc, m_tc, m_pc, m_filt;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst) begin
            m_mode = 0; m_learn = 1; m_prev = 0; m_hp = 0; m_ls = 0; m_ts = 0;
            m_hc = 0; m_lc = 0; m_tc = 0; m_pc = 0; m_filt = 0;
        end else begin
            int ln, tn, l, t, cls, v;
            ln = (smp_vld && m_hp && m_prev < 32 && smp > 96) ? 1 : 0;
            tn = (smp_vld && m_hp && m_prev > 96 && smp < 32) ? 1 : 0;
            l = m_ls | ln;
            t = m_ts | tn;
            cls = l ? 1 : (t ? 2 : 0);
            if (half_stb) begin
                m_ls = 0; m_ts = 0; m_hp = 0;
                if (m_learn) begin
                    m_hc++;
                    if (cls == 1) m_lc++;
                    if (cls == 2) m_tc++;
                    if (m_hc == 4) begin
                        v = (m_lc >= 2) ? 1 : ((m_tc >= 2) ? 2 : 0);
                        m_mode = v;
                        if (v != 0) begin
                            m_learn = 0; m_pc = 0; m_filt = 0;
                        end
                        m_hc = 0; m_lc = 0; m_tc = 0;
                    end
                end else begin
                    m_pc++;
                    if (m_pc == 16) begin
                        m_pc = 0;
                        if (cls != m_mode) begin
                            if (m_filt < 15) m_filt++;
                            if (m_filt >= 12) begin
                                m_learn = 1; m_filt = 0;
                            end
                        end else if (m_filt > 0) begin
                            m_filt--;
                        end
                    end
                end
            end else begin
                m_ls = l; m_ts = t;
                if (smp_vld) begin
                    m_prev = smp; m_hp = 1;
                end
            end
        end
    end

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc >= 100000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cyc);
            summary();
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one clock step: compare with model at the falling edge, then drive
    task automatic tick(bit v, int val, bit stb);
        @(negedge clk);
        if (!rst) begin
            chk("R6 mode vs model", mode_o, m_mode);
            chk("R7 learning vs model", learning_o, m_learn);
        end
        smp_vld  = v;
        smp      = val[7:0];
        half_stb = stb;
    endtask

    // shapes: 0 none, 1 leading, 2 trailing, 3 both, 4 high first sample, 5 drop on strobe
    function automatic int shape(int kind, int i);
        int none_s[10]  = '{0, 40, 80, 120, 160, 160, 120, 80, 40, 10};
        int lead_s[10]  = '{0, 0, 0, 0, 200, 220, 160, 100, 50, 10};
        int trail_s[10] = '{0, 40, 80, 120, 160, 200, 0, 0, 0, 0};
        int both_s[10]  = '{0, 0, 0, 0, 200, 220, 200, 0, 0, 0};
        int hi0_s[10]   = '{200, 220, 180, 140, 100, 70, 50, 40, 30, 20};
        int tstb_s[10]  = '{0, 40, 80, 120, 160, 180, 200, 210, 220, 0};
        case (kind)
            1: return lead_s[i];
            2: return trail_s[i];
            3: return both_s[i];
            4: return hi0_s[i];
            5: return tstb_s[i];
            default: return none_s[i];
        endcase
    endfunction

    task automatic run_half(int kind);
        for (int i = 0; i < 10; i++) begin
            tick(1'b1, shape(kind, i), (i == 9));
            if (i == 3) tick(1'b0, 0, 1'b0);   // gap between samples 3 and 4
        end
    endtask

    task automatic idle();
        tick(1'b0, 0, 1'b0);
    endtask

    // a validate period of 16 halves: 15 of kind a, the 16th of kind b
    task automatic period(int a, int b);
        for (int h = 0; h < 15; h++) run_half(a);
        run_half(b);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 mode in reset", mode_o, 0);
        chk("R1 learning in reset", learning_o, 1);
        rst = 1'b0;
        idle();
        chk("R1 mode after reset", mode_o, 0);
        chk("R1 learning after reset", learning_o, 1);

        // A: no dimmer seen
        for (int h = 0; h < 4; h++) run_half(0);
        idle();
        chk("R5 no-dimmer verdict", mode_o, 0);
        chk("R7 stays learning after none", learning_o, 1);

        // B: halves with both edges, leading wins
        run_half(3); run_half(3); run_half(0);
        idle();
        chk("R6 mode held before window end", mode_o, 0);
        run_half(0);
        idle();
        chk("R4 leading priority verdict", mode_o, 1);
        chk("R7 enters validate", learning_o, 0);

        // C: validate; off-schedule halves are ignored
        for (int p = 0; p < 13; p++) period(2, 1);
        idle();
        chk("R8 off-schedule halves ignored", learning_o, 0);
        chk("R10 mode held in validate", mode_o, 1);
        for (int p = 0; p < 11; p++) period(1, 2);
        idle();
        chk("R9 eleven mismatches keep validate", learning_o, 0);
        period(1, 1);
        period(1, 2);
        idle();
        chk("R9 match decrements count", learning_o, 0);
        period(1, 2);
        idle();
        chk("R9 count reaching 12 returns to learn", learning_o, 1);
        chk("R9 mode held on return", mode_o, 1);

        // D: drop on strobe sample, and a high first sample
        run_half(5); run_half(2); run_half(4); run_half(4);
        idle();
        chk("R3 R4 trailing verdict with strobe-cycle drop", mode_o, 2);
        chk("R2 first sample after strobe raises no event", learning_o, 0);

        repeat (4) idle();
        done = 1;
        summary();
    end

endmodule